// File: doc/BRIEF.md
# Macropixel Sparsified Hit Readout

This block is the edge-of-matrix readout for a binary pixel array of 128 columns by 32 rows. The array is tiled into 4x4 groups (macropixels), giving 32 group columns by 8 group rows. Each group has its own hit line into the block. A group that sees a hit is flagged at once and stamped with the current value of an 8-bit time counter. The counter advances on a separate tick input.

A sequencer then serves the flagged groups one at a time. It drives one group-column line and one group-row line, which are shared by all groups, to select a group. It reads that group's 16 pixel bits and its stamp over a shared bus. It then sends one 21-bit word for each pixel that was hit. Pixels with no hit produce no word. The output uses a valid/ready handshake. While the output is stalled, new hits keep being collected in the per-group storage.

Top module: `mpx_readout`

## Requirements
- R1: After reset, out_valid is 0, the time counter is 0 and no group is flagged.
- R2: Pixel (row r, column c) arrives on pix_hit bit 128*r+c, with row 0 at the top. The word it produces is laid out as follows. Bits 3:0 hold 4*(r mod 4)+(c mod 4). Bits 6:4 hold r/4. Bits 11:7 hold c/4. Bits 19:12 hold the time stamp. Bit 20 is the end-of-group flag.
- R3: A group produces exactly one word per hit pixel, in ascending pixel-index order. Only the group's last word has bit 20 set.
- R4: The time counter adds 1 on each clock edge where ts_tick is 1 and wraps from 255 to 0. The stamp in a word is the counter value in the cycle the group's first hit was sampled.
- R5: A group that is hit again while still flagged keeps its first stamp and adds the new pixels to its set.
- R6: When several groups are flagged, the one with the lowest group row is served first. Among groups in the same group row, the lowest group column goes first.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R8: Hits that arrive while the output is stalled are kept and read out later.
- R9: A group is read out once. After its last word is accepted, it produces no further words unless it is hit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_tick | input | 1 | Time counter advance strobe |
| pix_hit | input | 4096 | Single-cycle pixel hit pulses, bit 128*row+col |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | out_data holds a word |
| out_data | output | 21 | Formatted hit word |

## Verification
The assertions check several properties on every cycle. The output holds its value under backpressure. A flagged group never changes its stamp or drops a stored pixel until it is cleared. The arbiter always grants the lowest-numbered flagged group. At most one group line per axis is ever enabled. The time counter steps only on a tick. The bench scenarios cover what needs known stimulus to show. These are the exact word layout, the ascending per-pixel order and the end flag, the serving order across groups, stamp merging on a repeated hit, counter wrap, and the fact that a served group stays silent afterwards.

// File: rtl/mpx_pkg.sv
// Package: shared types for the macropixel readout.
// Assumes: nothing beyond IEEE 1800-2017.
package mpx_pkg;

    // Sequencer phases: waiting, reading a group, emitting words
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_EMIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/mpx_ts_counter.sv
// Module: free time counter advanced by an external tick.
// Assumes: tick is synchronous to clk; the count wraps naturally.
module mpx_ts_counter #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] ts
);

    // Count ticks, wrapping at 2**TS_W
    always_ff @(posedge clk) begin
        if (!rst_n)    ts <= '0;
        else if (tick) ts <= ts + 1'b1;
    end

    AST_TS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ts)); // R4
    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ts == TS_W'($past(ts) + 1)); // R4

endmodule

// File: rtl/mpx_group.sv
// Module: storage for one macropixel. Collects pixel hits, stamps the first
// hit and drives its bits and stamp onto the shared bus when enabled.
// Assumes: clr and clr_mask have meaning only while enable is high. Bits
// not named in clr_mask survive a clear and keep the stored stamp.
module mpx_group #(
    parameter int NPIX = 16,
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIX-1:0] hit,
    input  logic [TS_W-1:0] ts_now,
    input  logic            enable,
    input  logic            clr,
    input  logic [NPIX-1:0] clr_mask,
    output logic            pending,
    output logic [NPIX-1:0] rd_bits,
    output logic [TS_W-1:0] rd_ts
);

    logic [NPIX-1:0] bits_q;
    logic [TS_W-1:0] ts_q;
    logic [NPIX-1:0] bits_kept;
    logic            fresh;

    // Remove the bits already read out, then decide whether a new entry starts
    always_comb begin
        bits_kept = (enable && clr) ? (bits_q & ~clr_mask) : bits_q;
        fresh     = (bits_kept == '0) && (hit != '0);
    end

    // Accumulate hits and capture the stamp of the first one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            ts_q   <= '0;
        end else begin
            bits_q <= bits_kept | hit;
            if (fresh) ts_q <= ts_now;
        end
    end

    // Flag and gated bus drive
    always_comb begin
        pending = |bits_q;
        rd_bits = enable ? bits_q : '0;
        rd_ts   = enable ? ts_q : '0;
    end

    AST_STAMP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_q != '0) && !(enable && clr) |=> $stable(ts_q)); // R5
    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && clr) |=> (bits_q & $past(bits_q)) == $past(bits_q)); // R8

endmodule

// File: rtl/mpx_prio_arb.sv
// Module: fixed-priority pick of the lowest-numbered request.
// Assumes: group number = group_row * columns + group_column, so the lowest
// number is the lowest row first, then the lowest column.
module mpx_prio_arb #(
    parameter int N     = 256,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from high to low so the lowest request wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end

    // Check that the grant is a real request with nothing lower pending
    always_comb begin
        logic lower_clear;
        lower_clear = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (i < int'(idx) && req[i]) lower_clear = 1'b0;
        end
        AST_ARB_LOWEST: assert (!any || (req[idx] && lower_clear)); // R6
    end

endmodule

// File: rtl/mpx_sequencer.sv
// Module: serves flagged groups one at a time. Selects a group over the
// shared column/row lines, captures its bits and stamp, emits one word per
// hit pixel, then clears what it read.
// Assumes: the group number has the group column in its low MCOL_W bits.
module mpx_sequencer
    import mpx_pkg::*;
#(
    parameter int N_MCOL = 32,
    parameter int N_MROW = 8,
    parameter int NPIX   = 16,
    parameter int TS_W   = 8,
    localparam int MCOL_W = $clog2(N_MCOL),
    localparam int MROW_W = $clog2(N_MROW),
    localparam int IDX_W  = $clog2(NPIX),
    localparam int GRP_W  = MCOL_W + MROW_W,
    localparam int WORD_W = 1 + TS_W + MCOL_W + MROW_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_pend,
    input  logic [GRP_W-1:0]  win_idx,
    input  logic [NPIX-1:0]   bus_bits,
    input  logic [TS_W-1:0]   bus_ts,
    input  logic              out_ready,
    output logic [N_MCOL-1:0] col_en,
    output logic [N_MROW-1:0] row_en,
    output logic              clr,
    output logic [NPIX-1:0]   clr_mask,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    seq_state_e         state;
    logic [GRP_W-1:0]   sel_q;
    logic [NPIX-1:0]    left_q;
    logic [NPIX-1:0]    all_q;
    logic [TS_W-1:0]    ts_q;
    logic [MCOL_W-1:0]  sel_col;
    logic [MROW_W-1:0]  sel_row;
    logic [IDX_W-1:0]   low_idx;
    logic [NPIX-1:0]    left_after;
    logic               last;

    // Split the selected group number and drive one line per axis
    always_comb begin
        sel_col = sel_q[MCOL_W-1:0];
        sel_row = sel_q[GRP_W-1:MCOL_W];
        col_en  = '0;
        row_en  = '0;
        if (state != SEQ_IDLE) begin
            col_en[sel_col] = 1'b1;
            row_en[sel_row] = 1'b1;
        end
    end

    // Find the lowest remaining pixel and whether it is the last one
    always_comb begin
        low_idx = '0;
        for (int i = NPIX - 1; i >= 0; i--) begin
            if (left_q[i]) low_idx = IDX_W'(i);
        end
        left_after          = left_q;
        left_after[low_idx] = 1'b0;
        last                = (left_after == '0);
    end

    // Output word and clear strobe
    always_comb begin
        out_valid = (state == SEQ_EMIT);
        out_data  = {last, ts_q, sel_col, sel_row, low_idx};
        clr       = ((state == SEQ_LOAD) && (bus_bits == '0)) ||
                    ((state == SEQ_EMIT) && out_ready && last);
        clr_mask  = (state == SEQ_LOAD) ? bus_bits : all_q;
    end

    // Phase sequencing and capture of the selected group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            sel_q  <= '0;
            left_q <= '0;
            all_q  <= '0;
            ts_q   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (any_pend) begin
                        sel_q <= win_idx;
                        state <= SEQ_LOAD;
                    end
                end
                SEQ_LOAD: begin
                    left_q <= bus_bits;
                    all_q  <= bus_bits;
                    ts_q   <= bus_ts;
                    state  <= (bus_bits == '0) ? SEQ_IDLE : SEQ_EMIT;
                end
                SEQ_EMIT: begin
                    if (out_ready) begin
                        left_q <= left_after;
                        if (last) state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_data[WORD_W-1] |=> !out_valid); // R9
    AST_ONE_GROUP_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_en) && $onehot0(row_en)); // R3

endmodule

// File: rtl/mpx_readout.sv
// Module: top of the macropixel readout. Maps the pixel hit lines onto the
// per-group storage, merges the shared bus and connects the arbiter and
// the sequencer.
// Assumes: N_MCOL and N_MROW are powers of two; pixel bit = row*N_COL+col.
module mpx_readout #(
    parameter int N_MCOL  = 32,
    parameter int N_MROW  = 8,
    parameter int MP_SIDE = 4,
    parameter int TS_W    = 8,
    localparam int N_COL  = N_MCOL * MP_SIDE,
    localparam int N_ROW  = N_MROW * MP_SIDE,
    localparam int N_PIX  = N_COL * N_ROW,
    localparam int NPIX   = MP_SIDE * MP_SIDE,
    localparam int N_GRP  = N_MCOL * N_MROW,
    localparam int GRP_W  = $clog2(N_GRP),
    localparam int WORD_W = 1 + TS_W + $clog2(N_MCOL) + $clog2(N_MROW) + $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_tick,
    input  logic [N_PIX-1:0]  pix_hit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);

    logic [TS_W-1:0]   ts_now;
    logic [N_GRP-1:0]  pend;
    logic [NPIX-1:0]   grp_bits [N_GRP];
    logic [TS_W-1:0]   grp_ts   [N_GRP];
    logic [NPIX-1:0]   bus_bits;
    logic [TS_W-1:0]   bus_ts;
    logic [N_MCOL-1:0] col_en;
    logic [N_MROW-1:0] row_en;
    logic              clr;
    logic [NPIX-1:0]   clr_mask;
    logic              any_pend;
    logic [GRP_W-1:0]  win_idx;

    mpx_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ts_tick),
        .ts    (ts_now)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int GR = g / N_MCOL;
        localparam int GC = g % N_MCOL;
        logic [NPIX-1:0] hit_local;

        // Gather this group's pixel lines, row-major inside the group
        always_comb begin
            for (int p = 0; p < NPIX; p++) begin
                hit_local[p] = pix_hit[(GR * MP_SIDE + p / MP_SIDE) * N_COL
                                       + GC * MP_SIDE + p % MP_SIDE];
            end
        end

        mpx_group #(.NPIX(NPIX), .TS_W(TS_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit_local),
            .ts_now   (ts_now),
            .enable   (col_en[GC] & row_en[GR]),
            .clr      (clr),
            .clr_mask (clr_mask),
            .pending  (pend[g]),
            .rd_bits  (grp_bits[g]),
            .rd_ts    (grp_ts[g])
        );
    end

    // Shared data lines: wired-OR of the gated group outputs
    always_comb begin
        bus_bits = '0;
        bus_ts   = '0;
        for (int g = 0; g < N_GRP; g++) begin
            bus_bits = bus_bits | grp_bits[g];
            bus_ts   = bus_ts | grp_ts[g];
        end
    end

    mpx_prio_arb #(.N(N_GRP)) u_arb (
        .req (pend),
        .any (any_pend),
        .idx (win_idx)
    );

    mpx_sequencer #(
        .N_MCOL (N_MCOL),
        .N_MROW (N_MROW),
        .NPIX   (NPIX),
        .TS_W   (TS_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_pend  (any_pend),
        .win_idx   (win_idx),
        .bus_bits  (bus_bits),
        .bus_ts    (bus_ts),
        .out_ready (out_ready),
        .col_en    (col_en),
        .row_en    (row_en),
        .clr       (clr),
        .clr_mask  (clr_mask),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_NO_VALID_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

endmodule

// File: tb/mpx_readout_tb.sv
module mpx_readout_tb;

    localparam int N_PIX  = 4096;
    localparam int WORD_W = 21;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ts_tick = 1'b0;
    logic [N_PIX-1:0]  pix_hit = '0;
    logic              out_ready = 1'b1;
    logic              out_valid;
    logic [WORD_W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;

    always #2 clk = ~clk;

    mpx_readout u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ts_tick   (ts_tick),
        .pix_hit   (pix_hit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [WORD_W-1:0] mkw(bit eom, int ts, int row, int col);
        return {eom, 8'(ts % 256), 5'(col / 4), 3'(row / 4),
                4'((row % 4) * 4 + col % 4)};
    endfunction

    task automatic chk(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick_n(int n);
        if (n > 0) begin
            @(negedge clk);
            ts_tick = 1'b1;
            repeat (n) @(negedge clk);
            ts_tick = 1'b0;
            tcnt += n;
        end
    endtask

    task automatic hit(logic [N_PIX-1:0] v);
        @(negedge clk);
        pix_hit = v;
        @(negedge clk);
        pix_hit = '0;
    endtask

    function automatic logic [N_PIX-1:0] px(int row, int col);
        logic [N_PIX-1:0] v;
        v = '0;
        v[row * 128 + col] = 1'b1;
        return v;
    endfunction

    task automatic take(output logic [WORD_W-1:0] w);
        w = '1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (out_valid) begin
                w = out_data;
                break;
            end
        end
    endtask

    task automatic t_reset;
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk("R1 idle after reset", 21'(seen), 21'd0);
    endtask

    task automatic t_single;
        logic [WORD_W-1:0] w;
        hit(px(5, 9));
        take(w);
        chk("R1 R2 single pixel word, stamp 0", w, mkw(1, 0, 5, 9));
    endtask

    task automatic t_multi;
        logic [WORD_W-1:0] w;
        int ts;
        tick_n(3);
        ts = tcnt;
        hit(px(12, 40) | px(13, 43) | px(15, 43));
        take(w); chk("R3 first word idx0", w, mkw(0, ts, 12, 40));
        take(w); chk("R3 second word idx7", w, mkw(0, ts, 13, 43));
        take(w); chk("R3 last word idx15 with end flag", w, mkw(1, ts, 15, 43));
    endtask

    task automatic t_priority;
        logic [WORD_W-1:0] w;
        int ts;
        ts = tcnt;
        hit(px(8, 20) | px(4, 80) | px(4, 12));
        take(w); chk("R6 row1 col3 first", w, mkw(1, ts, 4, 12));
        take(w); chk("R6 row1 col20 second", w, mkw(1, ts, 4, 80));
        take(w); chk("R6 row2 col5 third", w, mkw(1, ts, 8, 20));
    endtask

    task automatic t_stall;
        logic [WORD_W-1:0] w, wa;
        int ta, tb;
        @(negedge clk);
        out_ready = 1'b0;
        tick_n(1);
        ta = tcnt;
        hit(px(0, 0));
        take(wa);
        chk("R7 stalled word", wa, mkw(1, ta, 0, 0));
        tick_n(1);
        tb = tcnt;
        hit(px(20, 100));
        chk("R7 held during stall", out_data, wa);
        chk("R7 valid held during stall", 21'(out_valid), 21'd1);
        tick_n(2);
        hit(px(21, 102));
        chk("R7 held after more hits", out_data, wa);
        @(negedge clk);
        out_ready = 1'b1;
        take(w); chk("R5 R8 first pixel of rehit group", w, mkw(0, tb, 20, 100));
        take(w); chk("R5 R8 merged pixel keeps first stamp", w, mkw(1, tb, 21, 102));
    endtask

    task automatic t_wrap;
        logic [WORD_W-1:0] w;
        tick_n(255 - (tcnt % 256));
        hit(px(30, 127));
        take(w); chk("R4 stamp 255", w, mkw(1, 255, 30, 127));
        tick_n(2);
        hit(px(31, 64));
        take(w); chk("R4 stamp wrapped to 1", w, mkw(1, 1, 31, 64));
    endtask

    task automatic t_once;
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk("R9 no repeat after last word", 21'(seen), 21'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_multi();
        t_priority();
        t_stall();
        t_wrap();
        t_once();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule